// File: doc/BRIEF.md
# I2C Master Error-Flag Supervisor

This block keeps the sticky error and status flags of an I2C master and decides whether the master may begin a new transaction. The bit-level engine feeds it single-cycle event strobes. These report a driven one read back as zero, a START or STOP seen on the bus, an acknowledge slot with its sampled level, a data phase requested without a START, and the controller's own START and STOP issues. The block also watches the raw SCL and SDA levels for a stuck-low line against a programmable limit.

Four sticky flags are kept: arbitration lost, unexpected acknowledge, data-without-START, and pin-low timeout. Each flag drives its own recovery request. Arbitration loss pulses a release-bus request and drops master-busy without any STOP. An acknowledge error or a data-without-START error on a busy master pulses a force-STOP request. While any flag is set, a START-inhibit output is held high. Software clears a flag by writing one to its bit. The pin-low flag refuses that clear while the low condition lasts.

Top module: `i2c_err_supervisor`

## Requirements
- R1: If bit_mismatch_i is high, or if tx_active_i is high together with start_det_i or stop_det_i, the arbitration flag (flags_o bit 0) reads 1 after the next clock edge. release_bus_o pulses high for that one cycle, force_stop_o stays low in that cycle, and mst_busy_o reads 0.
- R2: An acknowledge slot (ack_slot_i high; ack_level_i 1 = NACK, 0 = ACK) sets the acknowledge flag (bit 1) when nack_expected_i is 0 and the level is NACK. When nack_expected_i is 1 it sets the flag only when the level is ACK.
- R3: In the cycle after an acknowledge-flag set event, force_stop_o is high for one cycle, unless an arbitration event occurred at the same edge.
- R4: no_start_data_i sets the FIFO-error flag (bit 2). force_stop_o pulses in the next cycle only if mst_busy_o was 1 when the event arrived.
- R5: With pl_limit_i = L > 0, once SCL or SDA has been sampled low at L+2 consecutive clock edges, the pin-low flag (bit 3) reads 1. It does not read 1 after L+1 such edges. This check runs whether or not the master is busy.
- R6: A clear of bit 3 has no effect while the count has exceeded L and a line is still low.
- R7: pl_limit_i = 0 keeps the pin-low flag at 0. The low-cycle count restarts whenever both lines are sampled high.
- R8: start_inhibit_o is 1 exactly when any of the four flags is 1.
- R9: A 1 in flag_clr_i bit i clears flag i after the edge, and a 0 leaves it unchanged. A set event and a clear at the same edge leave the flag at 1.
- R10: bus_busy_o sets on start_det_i and clears on stop_det_i; START wins if both are high. mst_busy_o sets on own_start_i and clears on own_stop_i.
- R11: After reset, all flags, both busy bits and both request pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_mismatch_i | input | 1 | Driven one sampled as zero |
| tx_active_i | input | 1 | Master is transmitting a byte |
| start_det_i | input | 1 | START or repeated START detected on bus |
| stop_det_i | input | 1 | STOP detected on bus |
| ack_slot_i | input | 1 | Acknowledge bit sampled this cycle |
| ack_level_i | input | 1 | Sampled acknowledge level, 1 = NACK |
| nack_expected_i | input | 1 | Active command expects NACK |
| no_start_data_i | input | 1 | Data phase requested without START |
| own_start_i | input | 1 | Controller issued a START |
| own_stop_i | input | 1 | Controller issued a STOP |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| pl_limit_i | input | LIMW | Pin-low limit in cycles, 0 disables |
| flag_clr_i | input | 4 | Write-one-to-clear strobes for flags |
| flags_o | output | 4 | {pin-low, FIFO error, ack error, arbitration} |
| bus_busy_o | output | 1 | Any master active on bus |
| mst_busy_o | output | 1 | This controller active |
| force_stop_o | output | 1 | One-cycle request to send STOP |
| release_bus_o | output | 1 | One-cycle request to release bus |
| start_inhibit_o | output | 1 | New START not allowed |

## Verification
The hardest situation to reach is a pin-low clear attempted at the exact edge where the low count has just passed the limit. A second hard case is a set event colliding with a clear of the same flag. Random traffic seldom lines these up, because the lines must stay low for a precise number of edges while the clear strobe lands at the right point. The bench drives directed sequences with a small limit to count the L+1 and L+2 boundaries edge by edge. It pairs a clear with a still-low line and then with a set event in the same cycle. Random stimulus adds low bursts of random length against changing limits, and a cycle model follows every output.

// File: rtl/i2c_sup_pkg.sv
package i2c_sup_pkg;
  localparam int NFLAG   = 4;
  localparam int FL_ARB  = 0;
  localparam int FL_ACK  = 1;
  localparam int FL_FIFO = 2;
  localparam int FL_PIN  = 3;
endpackage

// File: rtl/i2c_sup_flag.sv
module i2c_sup_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic clr_block_i,
  input  logic zero_i,
  output logic q_o
);
  logic q_d, q_r;

  always_comb begin
    q_d = q_r;
    if (zero_i)                    q_d = 1'b0;
    else if (set_i)                q_d = 1'b1;
    else if (clr_i && !clr_block_i) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q_o = q_r;

  // R9: set beats a simultaneous clear
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !zero_i) |=> q_o);
  // R9: an unblocked clear takes effect
  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !clr_block_i) |=> !q_o);
  // R6: a blocked clear leaves the flag set
  assert_clear_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && clr_i && clr_block_i && !zero_i) |=> q_o);
endmodule

// File: rtl/i2c_sup_pinlow.sv
module i2c_sup_pinlow #(
  parameter int LIMW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic [LIMW-1:0] limit_i,
  output logic            hold_o
);
  localparam int CW = LIMW + 1;

  logic [CW-1:0] cnt_r, cnt_d;
  logic          low, enabled, over;

  always_comb begin
    low     = !scl_i || !sda_i;
    enabled = (limit_i != '0);
    over    = (cnt_r > {1'b0, limit_i});
    hold_o  = enabled && over && low;
  end

  always_comb begin
    cnt_d = cnt_r;
    if (!enabled || !low) cnt_d = '0;
    else if (!over)       cnt_d = cnt_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_r <= '0;
    else        cnt_r <= cnt_d;
  end

  // R5: the hold condition needs a line sampled low on the previous cycle too
  assert_hold_needs_history_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> $past(!scl_i || !sda_i));
  // R7: both lines high restarts the count
  assert_restart_on_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && sda_i) |=> !hold_o || $past(1'b0));
endmodule

// File: rtl/i2c_sup_busy.sv
module i2c_sup_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic own_start_i,
  input  logic own_stop_i,
  input  logic arb_evt_i,
  output logic bus_busy_o,
  output logic mst_busy_o
);
  logic bus_d, bus_r, mst_d, mst_r;

  always_comb begin
    bus_d = bus_r;
    if (start_det_i)     bus_d = 1'b1;
    else if (stop_det_i) bus_d = 1'b0;

    mst_d = mst_r;
    if (arb_evt_i)        mst_d = 1'b0;
    else if (own_start_i) mst_d = 1'b1;
    else if (own_stop_i)  mst_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_r <= 1'b0;
      mst_r <= 1'b0;
    end else begin
      bus_r <= bus_d;
      mst_r <= mst_d;
    end
  end

  assign bus_busy_o = bus_r;
  assign mst_busy_o = mst_r;

  // R10: a detected START marks the bus busy
  assert_bus_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det_i |=> bus_busy_o);
  // R10: a STOP alone frees the bus
  assert_bus_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det_i && !start_det_i) |=> !bus_busy_o);
  // R1: arbitration loss drops master-busy
  assert_arb_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
    arb_evt_i |=> !mst_busy_o);
endmodule

// File: rtl/i2c_err_supervisor.sv
module i2c_err_supervisor
  import i2c_sup_pkg::*;
#(
  parameter int LIMW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_mismatch_i,
  input  logic            tx_active_i,
  input  logic            start_det_i,
  input  logic            stop_det_i,
  input  logic            ack_slot_i,
  input  logic            ack_level_i,
  input  logic            nack_expected_i,
  input  logic            no_start_data_i,
  input  logic            own_start_i,
  input  logic            own_stop_i,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic [LIMW-1:0] pl_limit_i,
  input  logic [3:0]      flag_clr_i,
  output logic [3:0]      flags_o,
  output logic            bus_busy_o,
  output logic            mst_busy_o,
  output logic            force_stop_o,
  output logic            release_bus_o,
  output logic            start_inhibit_o
);
  // reset: asynchronous assert, synchronous release
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic arb_evt, ack_evt, fifo_evt, pl_hold;
  logic [NFLAG-1:0] set_v, blk_v, zero_v, flag_q;

  always_comb begin
    arb_evt  = bit_mismatch_i || (tx_active_i && (start_det_i || stop_det_i));
    ack_evt  = ack_slot_i && (nack_expected_i ? !ack_level_i : ack_level_i);
    fifo_evt = no_start_data_i;

    set_v          = '0;
    set_v[FL_ARB]  = arb_evt;
    set_v[FL_ACK]  = ack_evt;
    set_v[FL_FIFO] = fifo_evt;
    set_v[FL_PIN]  = pl_hold;

    blk_v          = '0;
    blk_v[FL_PIN]  = pl_hold;

    zero_v         = '0;
    zero_v[FL_PIN] = (pl_limit_i == '0);
  end

  i2c_sup_pinlow #(.LIMW(LIMW)) u_pinlow (
    .clk    (clk),
    .rst_n  (rs_n),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .limit_i(pl_limit_i),
    .hold_o (pl_hold)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    i2c_sup_flag u_flag (
      .clk        (clk),
      .rst_n      (rs_n),
      .set_i      (set_v[g]),
      .clr_i      (flag_clr_i[g]),
      .clr_block_i(blk_v[g]),
      .zero_i     (zero_v[g]),
      .q_o        (flag_q[g])
    );
  end

  i2c_sup_busy u_busy (
    .clk        (clk),
    .rst_n      (rs_n),
    .start_det_i(start_det_i),
    .stop_det_i (stop_det_i),
    .own_start_i(own_start_i),
    .own_stop_i (own_stop_i),
    .arb_evt_i  (arb_evt),
    .bus_busy_o (bus_busy_o),
    .mst_busy_o (mst_busy_o)
  );

  // recovery request pulses
  logic fstop_d, fstop_r, rel_d, rel_r;
  always_comb begin
    rel_d   = arb_evt;
    fstop_d = (ack_evt || (fifo_evt && mst_busy_o)) && !arb_evt;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      fstop_r <= 1'b0;
      rel_r   <= 1'b0;
    end else begin
      fstop_r <= fstop_d;
      rel_r   <= rel_d;
    end
  end

  assign flags_o         = flag_q;
  assign force_stop_o    = fstop_r;
  assign release_bus_o   = rel_r;
  assign start_inhibit_o = |flag_q;

  // R1: release without STOP
  assert_release_no_stop_R1: assert property (@(posedge clk) disable iff (!rs_n)
    release_bus_o |-> !force_stop_o);
  // R1: a fresh arbitration flag comes with a release request
  assert_arb_release_R1: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(flags_o[FL_ARB]) |-> release_bus_o);
  // R3: a fresh ack-error flag comes with a STOP or a release
  assert_ack_stop_R3: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(flags_o[FL_ACK]) |-> (force_stop_o || release_bus_o));
  // R7: zero limit keeps the pin-low flag clear
  assert_pin_disabled_R7: assert property (@(posedge clk) disable iff (!rs_n)
    (pl_limit_i == '0) |=> !flags_o[FL_PIN]);
endmodule

// File: tb/i2c_err_supervisor_tb.sv
module i2c_err_supervisor_tb_top;
  localparam int TCLK = 10;
  localparam int LIMW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic mism, txa, ss, sp, aslot, alev, nexp, nost, ostart, ostop, scl, sda;
  logic [LIMW-1:0] lim;
  logic [3:0] clr;
  logic [3:0] flags;
  logic bus_b, mst_b, fstop, rel, inh;

  always #(TCLK/2) clk = ~clk;

  i2c_err_supervisor #(.LIMW(LIMW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .bit_mismatch_i(mism), .tx_active_i(txa), .start_det_i(ss), .stop_det_i(sp),
    .ack_slot_i(aslot), .ack_level_i(alev), .nack_expected_i(nexp),
    .no_start_data_i(nost), .own_start_i(ostart), .own_stop_i(ostop),
    .scl_i(scl), .sda_i(sda), .pl_limit_i(lim), .flag_clr_i(clr),
    .flags_o(flags), .bus_busy_o(bus_b), .mst_busy_o(mst_b),
    .force_stop_o(fstop), .release_bus_o(rel), .start_inhibit_o(inh)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // expected state
  logic [3:0] m_fl;
  int         m_cnt;
  logic       m_bus, m_mst, m_fs, m_rel;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    mism = 0; txa = 0; ss = 0; sp = 0; aslot = 0; alev = 0; nexp = 0;
    nost = 0; ostart = 0; ostop = 0; scl = 1; sda = 1; clr = 0;
  endtask

  // one clock edge: advance the model, then compare at the falling edge
  task automatic cycle();
    bit arb, ackx, low, hold;
    int l;
    logic [3:0] setv;
    l    = int'(lim);
    arb  = mism | (txa & (ss | sp));
    ackx = aslot & (nexp ? ~alev : alev);
    low  = ~scl | ~sda;
    hold = (l != 0) && (m_cnt > l) && low;
    setv = {hold, nost, ackx, arb};
    @(posedge clk);
    m_fs  = (ackx | (nost & m_mst)) & ~arb;
    m_rel = arb;
    for (int i = 0; i < 4; i++) begin
      if (i == 3 && l == 0)                     m_fl[i] = 0;
      else if (setv[i])                         m_fl[i] = 1;
      else if (clr[i] && !(i == 3 && hold))     m_fl[i] = 0;
    end
    if (arb)         m_mst = 0;
    else if (ostart) m_mst = 1;
    else if (ostop)  m_mst = 0;
    if (ss)      m_bus = 1;
    else if (sp) m_bus = 0;
    if (l == 0 || !low) m_cnt = 0;
    else if (m_cnt <= l) m_cnt++;
    @(negedge clk);
    chk("R1 arb flag",     {3'b0, flags[0]}, {3'b0, m_fl[0]});
    chk("R2 ack flag",     {3'b0, flags[1]}, {3'b0, m_fl[1]});
    chk("R4 fifo flag",    {3'b0, flags[2]}, {3'b0, m_fl[2]});
    chk("R5 pin flag",     {3'b0, flags[3]}, {3'b0, m_fl[3]});
    chk("R1 release_bus",  {3'b0, rel},      {3'b0, m_rel});
    chk("R3 force_stop",   {3'b0, fstop},    {3'b0, m_fs});
    chk("R10 bus_busy",    {3'b0, bus_b},    {3'b0, m_bus});
    chk("R10 mst_busy",    {3'b0, mst_b},    {3'b0, m_mst});
    chk("R8 start_inhibit",{3'b0, inh},      {3'b0, |m_fl});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int burst;
    void'($urandom(32'h5EED_1234));
    idle_inputs();
    lim = 8'd3;
    rst_n = 0;
    m_fl = 0; m_cnt = 0; m_bus = 0; m_mst = 0; m_fs = 0; m_rel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 flags after reset", flags, 4'h0);
    chk("R11 busy/pulses after reset", {bus_b, mst_b, fstop, rel}, 4'h0);

    // R5 boundary with L=3: flag after L+2 low edges, not after L+1
    sda = 0; ostart = 1; ss = 1;
    cycle(); ostart = 0; ss = 0;
    for (int k = 2; k <= 4; k++) cycle();
    chk("R5 not yet after L+1 low edges", {3'b0, flags[3]}, 4'h0);
    cycle();
    chk("R5 set after L+2 low edges", {3'b0, flags[3]}, 4'h1);
    // R6 clear refused while low
    clr = 4'b1000; cycle();
    chk("R6 clear blocked while low", {3'b0, flags[3]}, 4'h1);
    chk("R8 inhibit with pin flag", {3'b0, inh}, 4'h1);
    clr = 0; sda = 1; cycle();
    clr = 4'b1000; cycle(); clr = 0;
    chk("R9 pin flag cleared after release", {3'b0, flags[3]}, 4'h0);

    // R7 disabled limit
    lim = 0; scl = 0;
    for (int k = 0; k < 20; k++) cycle();
    chk("R7 zero limit keeps flag clear", {3'b0, flags[3]}, 4'h0);
    scl = 1; lim = 8'd3; cycle();

    // R4 fifo error while master busy -> STOP request
    nost = 1; cycle(); nost = 0;
    chk("R4 fifo flag set", {3'b0, flags[2]}, 4'h1);
    chk("R4 stop when busy", {3'b0, fstop}, 4'h1);
    // R9 set and clear same edge
    nost = 1; clr = 4'b0100; cycle(); nost = 0; clr = 0;
    chk("R9 set wins over clear", {3'b0, flags[2]}, 4'h1);
    clr = 4'b1011; cycle(); clr = 0;
    chk("R9 zero bit leaves flag", {3'b0, flags[2]}, 4'h1);
    clr = 4'b0100; cycle(); clr = 0;
    chk("R9 clear works", {3'b0, flags[2]}, 4'h0);

    // R2 NACK expected
    aslot = 1; nexp = 1; alev = 1; cycle();
    chk("R2 expected NACK no flag", {3'b0, flags[1]}, 4'h0);
    alev = 0; cycle(); aslot = 0; nexp = 0;
    chk("R2 unexpected ACK sets flag", {3'b0, flags[1]}, 4'h1);
    chk("R3 stop after ack error", {3'b0, fstop}, 4'h1);

    // R1 start seen while transmitting
    txa = 1; ss = 1; cycle(); txa = 0; ss = 0;
    chk("R1 arb flag on START mid-tx", {3'b0, flags[0]}, 4'h1);
    chk("R1 release and idle", {rel, mst_b, fstop, 1'b0}, 4'b1000);
    clr = 4'b1111; cycle(); clr = 0;

    // random phase
    burst = 0;
    for (int n = 0; n < 4000; n++) begin
      idle_inputs();
      if (($urandom % 200) == 0) lim = LIMW'($urandom % 6);
      if (burst == 0 && ($urandom % 40) == 0) burst = 1 + $urandom % 10;
      if (burst > 0) begin
        burst--;
        scl = $urandom % 2; sda = scl ? 1'b0 : $urandom % 2;
      end
      mism   = ($urandom % 60) == 0;
      txa    = ($urandom % 3) == 0;
      ss     = ($urandom % 20) == 0;
      sp     = ($urandom % 20) == 0;
      aslot  = ($urandom % 15) == 0;
      alev   = $urandom % 2;
      nexp   = ($urandom % 4) == 0;
      nost   = ($urandom % 50) == 0;
      ostart = ($urandom % 12) == 0;
      ostop  = ($urandom % 12) == 0;
      if (($urandom % 6) == 0) clr = 4'($urandom);
      cycle();
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule